// File: doc/BRIEF.md
# Burst DMA Request Sequencer

This block sits on the host side of a network interface buffer and asks an external DMA engine for transfers in fixed-size bursts. Software programs two write-only registers through a simple write port. The enable register chooses whether the buffer is drained toward the host (receive, a read burst) or filled from the host (transmit, a write burst). The burst register picks how many transfers make up one burst. Whether each transfer moves a byte or a 16-bit word follows a system bus width input, and that width is reported with every burst.

The request/acknowledge pair toward the DMA engine is a valid/ready style handshake. `dma_req` is the valid side and `dma_ack` is the ready side, and a transfer happens on every clock edge where both are high. A low `dma_ack` holds the current transfer with no limit on how long. Once a burst has started, the request is never withdrawn, except by a clear command. Between two bursts the request drops for exactly one cycle.

A terminal-count signal from the engine, qualified by a transfer, ends the work. It raises a sticky end-of-process status and, when interrupts are enabled, an interrupt. No new burst starts until software clears the status by writing zeros to both enable bits. That same write also aborts any burst in progress.

Top module: `dma_burst_ctrl`

## Requirements
- R1: After reset, `dma_req`, `eop` and `irq` are low, both enables are off and the burst code is 0.
- R2: A write to the enable register (`cfg_sel`=0) with bit 1 set starts receive bursts, marked by `dma_rx`=1.
- R3: A write to the enable register with bit 1 clear and bit 0 set starts transmit bursts, marked by `dma_rx`=0.
- R4: When enable bits 1 and 0 are both set, receive wins and every burst has `dma_rx`=1.
- R5: In the burst register (`cfg_sel`=1), bits 1:0 = 0, 1, 2, 3 give bursts of 1, 2, 4 or 12 transfers. `dma_req` stays high until that many transfers are taken, then stays low for exactly one cycle before the next burst.
- R6: `dma_last` is high during the final transfer of each burst and low during the others.
- R7: `dma_word` equals the `word_mode` value captured when the burst started (1 = 16-bit word, 0 = byte) and stays fixed for the whole burst.
- R8: A transfer with `dma_tc` high sets `eop`, ends the burst, and keeps `dma_req` low until `eop` is cleared.
- R9: `irq` is high exactly while `eop` is set and `irq_en` is high.
- R10: A write of zero to both enable bits clears `eop` and `irq` and drops `dma_req` on that edge. The next burst then starts with a full transfer count.
- R11: Bits 7:2 of an enable-register write have no effect: a write of 0xFD behaves as a transmit-only enable.
- R12: `dma_ack` while `dma_req` is low takes no transfer, and the next burst still needs its full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 enable, 1 burst length |
| cfg_wdata | input | 8 | Write data |
| word_mode | input | 1 | System bus width: 1 word, 0 byte |
| irq_en | input | 1 | Interrupt enable for end-of-process |
| dma_ack | input | 1 | Transfer accepted by the DMA engine (ready) |
| dma_tc | input | 1 | Terminal count, meaningful with a transfer |
| dma_req | output | 1 | Transfer request (valid) |
| dma_rx | output | 1 | Direction of current burst: 1 receive read, 0 transmit write |
| dma_word | output | 1 | Transfer width of current burst |
| dma_last | output | 1 | Current transfer is the last one of the burst |
| eop | output | 1 | End-of-process status, sticky |
| irq | output | 1 | End-of-process interrupt |

## Verification
`dma_req` rises on the second edge after an enabling write strobe is presented: the first edge loads the register and the next starts the burst. A transfer is taken on the edge where request and acknowledge are both high, and the request is low for exactly one cycle after the last one. `eop` and `irq` change on the edge that takes a terminal-count transfer, and a clear acts on the edge of its own write. The bench drives inputs 2 ns after a rising edge and samples on the falling edge. Its scoreboard monitor pairs each sampled transfer with the burst expected at the head of the queue.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

  localparam int unsigned BEAT_W = 4;

  typedef enum logic [1:0] {
    BL_ONE    = 2'd0,
    BL_TWO    = 2'd1,
    BL_FOUR   = 2'd2,
    BL_TWELVE = 2'd3
  } burst_code_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } seq_state_e;

  function automatic logic [BEAT_W-1:0] burst_len(input burst_code_e code);
    case (code)
      BL_ONE:  burst_len = BEAT_W'(1);
      BL_TWO:  burst_len = BEAT_W'(2);
      BL_FOUR: burst_len = BEAT_W'(4);
      default: burst_len = BEAT_W'(12);
    endcase
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_burst_pkg::*;
#(
  parameter int unsigned CFG_W  = 8,
  parameter int unsigned RX_BIT = 1,
  parameter int unsigned TX_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             rx_en,
  output logic             tx_en,
  output burst_code_e      burst_code,
  output logic             clr_cmd
);

  logic en_wr, len_wr;
  logic unused_rsvd;

  assign en_wr   = cfg_wr && !cfg_sel;
  assign len_wr  = cfg_wr && cfg_sel;
  assign clr_cmd = en_wr && !cfg_wdata[RX_BIT] && !cfg_wdata[TX_BIT];

  // reserved bits of the enable write carry no function
  assign unused_rsvd = ^cfg_wdata[CFG_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en      <= 1'b0;
      tx_en      <= 1'b0;
      burst_code <= BL_ONE;
    end else begin
      if (en_wr) begin
        rx_en <= cfg_wdata[RX_BIT];
        tx_en <= cfg_wdata[TX_BIT];
      end
      if (len_wr) burst_code <= burst_code_e'(cfg_wdata[1:0]);
    end
  end

  p_clear_disables_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> !rx_en && !tx_en);

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_burst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        abort,
  input  logic        want_rx,
  input  logic        word_mode,
  input  burst_code_e burst_code,
  input  logic        dma_ack,
  input  logic        dma_tc,
  output logic        dma_req,
  output logic        dma_rx,
  output logic        dma_word,
  output logic        dma_last,
  output logic        tc_hit
);

  seq_state_e        state;
  logic [BEAT_W-1:0] cnt, len_q;
  logic              beat;

  assign dma_req  = (state == ST_BURST);
  assign beat     = dma_req && dma_ack;
  assign dma_last = dma_req && (cnt == len_q - BEAT_W'(1));
  assign tc_hit   = beat && dma_tc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      len_q    <= BEAT_W'(1);
      dma_rx   <= 1'b0;
      dma_word <= 1'b0;
    end else if (abort) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (run) begin
            state    <= ST_BURST;
            cnt      <= '0;
            len_q    <= burst_len(burst_code);
            dma_rx   <= want_rx;
            dma_word <= word_mode;
          end
        end
        default: begin
          if (beat) begin
            if (dma_last || dma_tc) begin
              state <= ST_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + BEAT_W'(1);
            end
          end
        end
      endcase
    end
  end

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_ack && !abort |=> dma_req);
  p_gap_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat && dma_last |=> !dma_req);
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len_q);
  p_dir_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req || $stable(dma_rx));
  p_width_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req || $stable(dma_word));
  p_abort_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !dma_req);

endmodule

// File: rtl/dma_eop_status.sv
module dma_eop_status #(
  parameter bit IRQ_REG = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_eop,
  input  logic clr_eop,
  input  logic irq_en,
  output logic eop,
  output logic irq
);

  logic eop_d;

  always_comb begin
    eop_d = eop;
    if (set_eop) eop_d = 1'b1;
    if (clr_eop) eop_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eop <= 1'b0;
    else        eop <= eop_d;
  end

  generate
    if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= eop_d && irq_en;
      end
    end else begin : g_irq_comb
      assign irq = eop && irq_en;
    end
  endgenerate

  p_eop_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eop && !clr_eop |=> eop);
  p_eop_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_eop |=> !eop);

endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl
  import dma_burst_pkg::*;
#(
  parameter int unsigned CFG_W   = 8,
  parameter bit          IRQ_REG = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             word_mode,
  input  logic             irq_en,
  input  logic             dma_ack,
  input  logic             dma_tc,
  output logic             dma_req,
  output logic             dma_rx,
  output logic             dma_word,
  output logic             dma_last,
  output logic             eop,
  output logic             irq
);

  logic        rx_en, tx_en, clr_cmd, tc_hit, run;
  burst_code_e burst_code;

  dma_cfg_regs #(.CFG_W(CFG_W), .RX_BIT(1), .TX_BIT(0)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .rx_en      (rx_en),
    .tx_en      (tx_en),
    .burst_code (burst_code),
    .clr_cmd    (clr_cmd)
  );

  // receive has priority: direction follows rx_en whenever it is set
  assign run = (rx_en || tx_en) && !eop;

  dma_burst_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .abort      (clr_cmd),
    .want_rx    (rx_en),
    .word_mode  (word_mode),
    .burst_code (burst_code),
    .dma_ack    (dma_ack),
    .dma_tc     (dma_tc),
    .dma_req    (dma_req),
    .dma_rx     (dma_rx),
    .dma_word   (dma_word),
    .dma_last   (dma_last),
    .tc_hit     (tc_hit)
  );

  dma_eop_status #(.IRQ_REG(IRQ_REG)) u_eop (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_eop (tc_hit),
    .clr_eop (clr_cmd),
    .irq_en  (irq_en),
    .eop     (eop),
    .irq     (irq)
  );

  p_eop_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> !dma_req);
  p_clear_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> !irq && !dma_req);
  p_tc_sets_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_ack && dma_tc && !clr_cmd |=> eop);

endmodule

// File: tb/dma_burst_ctrl_tb.sv
module dma_burst_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       word_mode = 1'b0, irq_en = 1'b0, dma_ack = 1'b0, dma_tc = 1'b0;
  logic       dma_req, dma_rx, dma_word, dma_last, eop, irq;

  always #4 clk = ~clk;

  dma_burst_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .word_mode(word_mode), .irq_en(irq_en),
    .dma_ack(dma_ack), .dma_tc(dma_tc), .dma_req(dma_req), .dma_rx(dma_rx),
    .dma_word(dma_word), .dma_last(dma_last), .eop(eop), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  typedef struct {bit rx; bit word; int len;} exp_t;
  exp_t sb[$];
  bit mon_on = 0;
  bit gap_due = 0;
  int beat = 0;
  int done_cnt = 0;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (gap_due) begin
        chk("R5 one-cycle gap", dma_req, 0);
        gap_due = 0;
      end else if (beat > 0 && !dma_req) begin
        chk("R5 request held in burst", dma_req, 1);
      end else if (dma_req && dma_ack) begin
        if (sb.size() == 0) begin
          chk("R12 unexpected transfer", 1, 0);
        end else begin
          beat++;
          chk("R2 R3 R4 R11 direction", dma_rx, sb[0].rx);
          chk("R7 width", dma_word, sb[0].word);
          chk("R6 last flag", dma_last, beat == sb[0].len);
          if (beat == sb[0].len) begin
            void'(sb.pop_front());
            beat = 0;
            done_cnt++;
            gap_due = 1;
          end
        end
      end
    end
  end

  task automatic wr(input bit sel, input logic [7:0] d);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_wr = 0; cfg_wdata = '0;
  endtask

  task automatic run_bursts(input bit rx, input logic [7:0] en, input logic [1:0] code,
                            input bit word, input int len, input int n);
    int target;
    mon_on = 1;
    word_mode = word;
    dma_ack = 1;                       // R12: acknowledge while idle
    wr(1, {6'd0, code});
    repeat (3) @(posedge clk);
    #2 chk("R12 no request while disabled", dma_req, 0);
    target = done_cnt + n;
    for (int i = 0; i < n; i++) sb.push_back('{rx, word, len});
    wr(0, en);
    while (done_cnt < target) begin @(posedge clk); #2; end
    dma_ack = 0;
    wr(0, 8'h00);
    chk("R10 request dropped by clear", dma_req, 0);
    chk("R5 all bursts seen", sb.size(), 0);
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset req", dma_req, 0);
    chk("R1 reset eop", eop, 0);
    chk("R1 reset irq", irq, 0);
    rst_n = 1;
    @(posedge clk); #2;
    chk("R1 idle after reset", dma_req, 0);

    run_bursts(1, 8'h02, 2'd2, 1, 4, 3);    // R2 receive, 4 transfers, words
    run_bursts(0, 8'h01, 2'd0, 0, 1, 4);    // R3 transmit, 1 transfer, bytes
    run_bursts(1, 8'h03, 2'd1, 0, 2, 2);    // R4 both set
    run_bursts(0, 8'hFD, 2'd3, 1, 12, 2);   // R11 reserved bits

    // R8 / R9 terminal count
    mon_on = 0;
    irq_en = 1;
    wr(1, 8'h03);
    wr(0, 8'h01);
    @(posedge clk); #2;
    chk("R3 request before terminal count", dma_req, 1);
    dma_ack = 1; dma_tc = 1;
    @(posedge clk); #2;
    dma_ack = 0; dma_tc = 0;
    chk("R8 eop set", eop, 1);
    chk("R8 request dropped", dma_req, 0);
    chk("R9 irq raised", irq, 1);
    repeat (4) @(posedge clk);
    #2 chk("R8 no request while eop", dma_req, 0);
    irq_en = 0;
    #1 chk("R9 irq masked", irq, 0);
    irq_en = 1;
    #1 chk("R9 irq unmasked", irq, 1);
    wr(0, 8'h00);
    chk("R10 eop cleared", eop, 0);
    chk("R10 irq cleared", irq, 0);

    // R10 abort mid-burst, then a full fresh burst
    wr(1, 8'h03);
    wr(0, 8'h02);
    @(posedge clk); #2;
    chk("R2 request up", dma_req, 1);
    dma_ack = 1;
    @(posedge clk); #2;
    dma_ack = 0;
    chk("R5 held after one transfer", dma_req, 1);
    chk("R6 not last yet", dma_last, 0);
    wr(0, 8'h00);
    chk("R10 abort drops request", dma_req, 0);
    run_bursts(1, 8'h02, 2'd3, 0, 12, 1);   // R10 full count after abort

    finish_run();
  end

endmodule